// File: doc/BRIEF.md
# Coprocessor Bus Request and Reset Arbiter

This block lets a main processor govern a secondary 8-bit sound processor through two control bits that the main processor writes: a bus-request bit and an active-low reset bit. From these it keeps a 2-bit state. That state decides whether the secondary processor runs. It also decides whether the main processor may reach into the secondary bus, and whether the attached sound chip is held in reset. When reset is released, the block emits a one-clock reset pulse to the secondary processor.

The main processor's access window into the secondary bus is gated here. While the window is closed, reads see a fixed open-bus value and writes never reach the secondary bus. The window opens only when the bus is requested and the secondary processor is out of reset. All control outputs are registered. Each one changes on the clock edge that takes in the control write.

Top module: `coproc_bus_arbiter`

## Requirements
- R1: After system reset, the state is 0. In that state sub_run, sub_grant and sub_rst_pulse are 0 and snd_rst is 1.
- R2: sub_run is 1 exactly when the state is 1, where state bit 0 is reset released and state bit 1 is bus requested.
- R3: sub_grant is 1 exactly when the state is 3. It is registered, so it changes on the clock edge that samples the control write.
- R4: While sub_grant is 1, host_rd_data equals sub_rd_data and sub_wr_en follows host_wr_en. While sub_grant is 0, host_rd_data equals OPEN_BUS (default all ones) and sub_wr_en is 0.
- R5: A reset write with ctl_rst_bit=1 (release) taken in state 0 or 2 raises sub_rst_pulse for exactly one clock, and snd_rst is 1 in that clock.
- R6: A release write taken in state 1 or 3 produces no pulse on sub_rst_pulse.
- R7: A reset write with ctl_rst_bit=0 (assert) clears state bit 0 and keeps bit 1. snd_rst stays 1 for as long as bit 0 is clear.
- R8: A request write with ctl_req_bit=1 sets state bit 1. A request write with ctl_req_bit=0 clears bit 1 and keeps bit 0.
- R9: When a request write and a reset write arrive in the same cycle, both bits update together. The pulse decision uses the state from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ctl_req_we | input | 1 | Write strobe for the bus-request bit |
| ctl_req_bit | input | 1 | Request value: 1 requests the bus, 0 releases it |
| ctl_rst_we | input | 1 | Write strobe for the reset bit |
| ctl_rst_bit | input | 1 | Reset value: 1 releases reset, 0 asserts it |
| host_wr_en | input | 1 | Main-processor write strobe into the window |
| sub_rd_data | input | DATA_W | Read data from the secondary bus |
| sub_run | output | 1 | Run enable for the secondary processor |
| sub_grant | output | 1 | Main-processor window into the secondary bus is open |
| sub_rst_pulse | output | 1 | One-clock reset pulse to the secondary processor |
| snd_rst | output | 1 | Reset/hold for the sound chip |
| host_rd_data | output | DATA_W | Window read data seen by the main processor |
| sub_wr_en | output | 1 | Gated write strobe onto the secondary bus |

## Verification
The bench drives the block through every transition between states and into both the pulse and no-pulse release cases. States 0 and 2 look identical at the ports, so the bench tells them apart by releasing reset afterwards. A design that lost bit 1 on a reset assert would then show run instead of grant. Simultaneous request and reset writes are aimed at a design that decides the pulse from the new state, which would either miss the pulse or repeat it. A design that combined the grant with a combinational path, or opened the window one cycle late, fails the per-clock comparison of the window's read data and write strobe.

// File: rtl/coproc_arb_pkg.sv
package coproc_arb_pkg;

   localparam int ARB_ST_W = 2;
   localparam int RELEASE_BIT = 0;
   localparam int REQUEST_BIT = 1;

   typedef enum logic [ARB_ST_W-1:0] {
      ARB_HELD      = 2'b00,
      ARB_RUNNING   = 2'b01,
      ARB_HELD_REQ  = 2'b10,
      ARB_GRANTED   = 2'b11
   } arb_state_t;

endpackage

// File: rtl/cab_state.sv
module cab_state
   import coproc_arb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_we,
   input  logic       req_bit,
   input  logic       rls_we,
   input  logic       rls_bit,
   output arb_state_t state_q,
   output arb_state_t state_d,
   output logic       release_evt
);

   logic [ARB_ST_W-1:0] nxt;

   always_comb begin
      nxt = state_q;
      if (req_we) nxt[REQUEST_BIT] = req_bit;
      if (rls_we) nxt[RELEASE_BIT] = rls_bit;
      state_d = arb_state_t'(nxt);
   end

   // Release taken while reset was still held (from state 0 or 2).
   assign release_evt = rls_we & rls_bit & ~state_q[RELEASE_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ARB_HELD;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/cab_outputs.sv
module cab_outputs
   import coproc_arb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  arb_state_t state_d,
   input  logic       release_evt,
   output logic       run_q,
   output logic       grant_q,
   output logic       pulse_q,
   output logic       snd_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         grant_q <= 1'b0;
         pulse_q <= 1'b0;
         snd_q   <= 1'b1;
      end else begin
         run_q   <= (state_d == ARB_RUNNING);
         grant_q <= (state_d == ARB_GRANTED);
         pulse_q <= release_evt;
         snd_q   <= ~state_d[RELEASE_BIT] | release_evt;
      end
   end

endmodule

// File: rtl/cab_window.sv
module cab_window #(
   parameter int                DATA_W   = 8,
   parameter logic [DATA_W-1:0] OPEN_BUS = '1
) (
   input  logic              grant,
   input  logic              host_wr_en,
   input  logic [DATA_W-1:0] sub_rd_data,
   output logic [DATA_W-1:0] host_rd_data,
   output logic              sub_wr_en
);

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign host_rd_data[b] = grant ? sub_rd_data[b] : OPEN_BUS[b];
   end

   assign sub_wr_en = grant & host_wr_en;

endmodule

// File: rtl/coproc_bus_arbiter.sv
module coproc_bus_arbiter
   import coproc_arb_pkg::*;
#(
   parameter int                DATA_W   = 8,
   parameter logic [DATA_W-1:0] OPEN_BUS = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_req_we,
   input  logic              ctl_req_bit,
   input  logic              ctl_rst_we,
   input  logic              ctl_rst_bit,
   input  logic              host_wr_en,
   input  logic [DATA_W-1:0] sub_rd_data,
   output logic              sub_run,
   output logic              sub_grant,
   output logic              sub_rst_pulse,
   output logic              snd_rst,
   output logic [DATA_W-1:0] host_rd_data,
   output logic              sub_wr_en
);

   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_width
      $error("coproc_bus_arbiter: DATA_W out of range");
   end

   arb_state_t state_q, state_d;
   logic       release_evt;

   cab_state u_state (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_we      (ctl_req_we),
      .req_bit     (ctl_req_bit),
      .rls_we      (ctl_rst_we),
      .rls_bit     (ctl_rst_bit),
      .state_q     (state_q),
      .state_d     (state_d),
      .release_evt (release_evt)
   );

   cab_outputs u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .state_d     (state_d),
      .release_evt (release_evt),
      .run_q       (sub_run),
      .grant_q     (sub_grant),
      .pulse_q     (sub_rst_pulse),
      .snd_q       (snd_rst)
   );

   cab_window #(.DATA_W(DATA_W), .OPEN_BUS(OPEN_BUS)) u_win (
      .grant        (sub_grant),
      .host_wr_en   (host_wr_en),
      .sub_rd_data  (sub_rd_data),
      .host_rd_data (host_rd_data),
      .sub_wr_en    (sub_wr_en)
   );

endmodule

// File: rtl/coproc_bus_arbiter_chk.sv
module coproc_bus_arbiter_chk (
   input logic clk,
   input logic rst_n,
   input logic ctl_req_we,
   input logic ctl_req_bit,
   input logic ctl_rst_we,
   input logic ctl_rst_bit,
   input logic host_wr_en,
   input logic sub_run,
   input logic sub_grant,
   input logic sub_rst_pulse,
   input logic snd_rst,
   input logic sub_wr_en
);

   p_run_grant_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(sub_run && sub_grant));

   p_grant_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sub_grant) |-> $past(ctl_req_we || ctl_rst_we));

   p_closed_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sub_grant && host_wr_en) |-> !sub_wr_en);

   p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sub_rst_pulse |=> !sub_rst_pulse);

   p_pulse_snd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sub_rst_pulse |-> snd_rst);

   p_assert_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rst_we && !ctl_rst_bit) |=> (snd_rst && !sub_run && !sub_grant));

   p_drop_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_req_we && !ctl_req_bit) |=> !sub_grant);

endmodule

bind coproc_bus_arbiter coproc_bus_arbiter_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ctl_req_we    (ctl_req_we),
   .ctl_req_bit   (ctl_req_bit),
   .ctl_rst_we    (ctl_rst_we),
   .ctl_rst_bit   (ctl_rst_bit),
   .host_wr_en    (host_wr_en),
   .sub_run       (sub_run),
   .sub_grant     (sub_grant),
   .sub_rst_pulse (sub_rst_pulse),
   .snd_rst       (snd_rst),
   .sub_wr_en     (sub_wr_en)
);

// File: tb/coproc_bus_arbiter_bench.sv
`timescale 1ns/1ps
module coproc_bus_arbiter_bench;

   localparam int DW = 8;
   localparam logic [DW-1:0] OPEN_VAL = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_we = 1'b0, req_b = 1'b0, rst_we = 1'b0, rst_b = 1'b0;
   logic hwr = 1'b0;
   logic [DW-1:0] srd = '0;
   logic run, grant, pulse, snd, swr;
   logic [DW-1:0] hrd;

   int checks = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   coproc_bus_arbiter #(.DATA_W(DW), .OPEN_BUS(OPEN_VAL)) u_coproc_bus_arbiter (
      .clk(clk), .rst_n(rst_n),
      .ctl_req_we(req_we), .ctl_req_bit(req_b),
      .ctl_rst_we(rst_we), .ctl_rst_bit(rst_b),
      .host_wr_en(hwr), .sub_rd_data(srd),
      .sub_run(run), .sub_grant(grant), .sub_rst_pulse(pulse),
      .snd_rst(snd), .host_rd_data(hrd), .sub_wr_en(swr)
   );

   // Behavioural reference: integer state, bit0 = released, bit1 = requested.
   int m_st = 0;
   bit m_pulse = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0;
         m_pulse = 0;
      end else begin
         int ns;
         ns = m_st;
         m_pulse = rst_we && rst_b && (m_st % 2 == 0);
         if (req_we) ns = req_b ? (ns | 2) : (ns & 1);
         if (rst_we) ns = rst_b ? (ns | 1) : (ns & 2);
         m_st = ns;
      end
   end

   task automatic check(input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Every-clock comparison against the model.
   always @(negedge clk) begin
      if (rst_n) begin
         check("R2", "sub_run", DW'(run), DW'(m_st == 1));
         check("R3", "sub_grant", DW'(grant), DW'(m_st == 3));
         check("R5", "sub_rst_pulse", DW'(pulse), DW'(m_pulse));
         check("R7", "snd_rst", DW'(snd), DW'((m_st % 2 == 0) || m_pulse));
         check("R4", "host_rd_data", hrd, (m_st == 3) ? srd : OPEN_VAL);
         check("R4", "sub_wr_en", DW'(swr), DW'((m_st == 3) && hwr));
      end
   end

   task automatic drive(input logic rq_we, input logic rq, input logic rs_we, input logic rs);
      @(posedge clk);
      #1;
      req_we = rq_we; req_b = rq; rst_we = rs_we; rst_b = rs;
      hwr = $urandom_range(0, 1);
      srd = DW'($urandom);
   endtask

   task automatic idle();
      drive(1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic step_check(input string req, input logic e_run, input logic e_grant,
                             input logic e_pulse, input logic e_snd);
      idle();
      @(negedge clk);
      check(req, "run", DW'(run), DW'(e_run));
      check(req, "grant", DW'(grant), DW'(e_grant));
      check(req, "pulse", DW'(pulse), DW'(e_pulse));
      check(req, "snd", DW'(snd), DW'(e_snd));
   endtask

   bit done = 0;

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      @(negedge clk);
      // R1: reset state
      check("R1", "run in reset", DW'(run), '0);
      check("R1", "snd in reset", DW'(snd), DW'(1));
      rst_n = 1'b1;
      repeat (2) idle();
      @(negedge clk);
      check("R1", "grant after reset", DW'(grant), '0);

      drive(1'b0, 1'b0, 1'b1, 1'b1);           // 0 -> 1 release
      step_check("R5", 1, 0, 1, 1);
      @(negedge clk);
      check("R5", "pulse one clock", DW'(pulse), '0);
      drive(1'b0, 1'b0, 1'b1, 1'b1);           // release again in 1
      step_check("R6", 1, 0, 0, 0);
      drive(1'b1, 1'b1, 1'b0, 1'b0);           // request: 1 -> 3
      step_check("R8", 0, 1, 0, 0);
      repeat (6) idle();                         // window traffic, R4
      drive(1'b0, 1'b0, 1'b1, 1'b1);           // release in 3
      step_check("R6", 0, 1, 0, 0);
      drive(1'b1, 1'b0, 1'b0, 1'b0);           // drop request: 3 -> 1
      step_check("R8", 1, 0, 0, 0);
      drive(1'b0, 1'b0, 1'b1, 1'b0);           // assert reset: 1 -> 0
      step_check("R7", 0, 0, 0, 1);
      drive(1'b1, 1'b1, 1'b0, 1'b0);           // 0 -> 2
      step_check("R8", 0, 0, 0, 1);
      drive(1'b0, 1'b0, 1'b1, 1'b1);           // 2 -> 3 with pulse
      step_check("R5", 0, 1, 1, 1);
      drive(1'b0, 1'b0, 1'b1, 1'b0);           // assert in 3 -> 2, bit1 kept
      step_check("R7", 0, 0, 0, 1);
      drive(1'b1, 1'b0, 1'b1, 1'b1);           // both writes from 2 -> 1
      step_check("R9", 1, 0, 1, 1);
      drive(1'b1, 1'b1, 1'b1, 1'b0);           // both writes from 1 -> 2
      step_check("R9", 0, 0, 0, 1);
      drive(1'b1, 1'b1, 1'b1, 1'b1);           // both from 2 -> 3
      step_check("R9", 0, 1, 1, 1);

      for (int i = 0; i < 400; i++) begin
         drive($urandom_range(0, 1), $urandom_range(0, 1),
               $urandom_range(0, 1), $urandom_range(0, 1));
      end
      repeat (3) idle();
      @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule